// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the eight status bits of an asynchronous serial port. It tracks whether the transmit buffer is empty and whether the transmitter has gone idle. It also tracks whether a received byte is waiting, the three receive error conditions, the multiprocessor bit of the last accepted character, and the multiprocessor bit to send with the next character. The transmitter and receiver engines report events as single-cycle pulses. The CPU reads the register through a byte port and clears flags by writing zeros.

A CPU write of 0 clears an error or data flag only when the CPU has already seen that flag as 1 in an earlier status read. Any status write consumes those permissions. If a flag is set again by hardware after the read, the permission for that flag is withdrawn, so a new event survives a stale clear. A write to the transmit buffer and a read of the receive buffer are separate strobes, and each gives its own clear path. A transmit-enable level that is low holds both transmit flags set.

Top module: `sci_status_reg`

## Requirements
- R1: After reset the status byte reads 8'h84: bit 7 (transmit buffer empty) and bit 2 (transmit done) are 1, all other bits are 0.
- R2: The status byte layout is bit 7 transmit empty, bit 6 receive full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit done, bit 1 received multiprocessor bit, bit 0 transmit multiprocessor bit; it is read combinationally.
- R3: Writing 0 to one of bits 7..3 clears that flag only if a status read earlier showed it as 1 and no status write came in between. Writing 1 to bits 7..3, or writing 0 without such a read, leaves the flag unchanged.
- R4: A status read arms each of bits 7..3 that reads 1. Every status write disarms all of them. A hardware set of a flag disarms that flag.
- R5: When a hardware set and any clear of the same flag fall in the same cycle, the flag ends up set.
- R6: Transmit empty is set while transmit enable is low or on a buffer-to-shifter transfer pulse. It is cleared by a transmit buffer write or by the armed write-0 on bit 7.
- R7: Transmit done is set while transmit enable is low or on a last-bit pulse while transmit empty is 1. It is cleared by a transmit buffer write or by the armed write-0 on bit 7. Writes to bit 2 are ignored.
- R8: A receive-complete pulse with receive full at 0, stop bit 1 and no parity error sets receive full. A receive buffer read clears it.
- R9: A receive-complete pulse while receive full is 1 sets overrun and leaves receive full and the received multiprocessor bit unchanged.
- R10: A receive-complete pulse with receive full at 0 sets the framing flag when the stop bit is 0, and sets the parity flag when the parity error input is 1. In either case receive full stays 0.
- R11: A receive-complete pulse with receive full at 0 loads bit 1 from the received multiprocessor bit. Every status write loads bit 0 from write data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | CPU status read strobe |
| wr_en | input | 1 | CPU status write strobe |
| wr_data | input | 8 | CPU status write data |
| rd_data | output | 8 | Status byte |
| txbuf_wr | input | 1 | CPU wrote the transmit buffer |
| rxbuf_rd | input | 1 | CPU read the receive buffer |
| tx_enable | input | 1 | Transmit enable control level |
| tx_load | input | 1 | Transmit buffer moved into the shifter |
| tx_last_bit | input | 1 | Last bit of a character sent |
| rx_done | input | 1 | Receive complete pulse |
| rx_stop_bit | input | 1 | Sampled stop bit, valid with rx_done |
| rx_parity_bad | input | 1 | Parity mismatch, valid with rx_done |
| rx_mpb | input | 1 | Received multiprocessor bit, valid with rx_done |
| mpb_tx | output | 1 | Multiprocessor bit to transmit |

## Verification
The clear path is tried four ways: a write of 0 with no read, a write of 1 after a read, a write of 0 after a read, and a write of 0 after a second write has used up the read. Together these separate the read-arming logic from plain write decoding. Receive-complete pulses are applied with receive full clear and set, with a bad stop bit, and with a bad parity flag, which shows how the data, overrun and error flags are kept apart. Collision cases put a hardware set between a read and a write, and in the same cycle as the write, to show that new events are never lost.

// File: rtl/sci_status_reg.sv
module sci_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       txbuf_wr,
  input  logic       rxbuf_rd,
  input  logic       tx_enable,
  input  logic       tx_load,
  input  logic       tx_last_bit,
  input  logic       rx_done,
  input  logic       rx_stop_bit,
  input  logic       rx_parity_bad,
  input  logic       rx_mpb,
  output logic       mpb_tx
);

  logic txe, rxf, ovr, frm, par, txd, mpb_rx;
  logic [4:0] arm;

  wire [4:0] flags5 = {txe, rxf, ovr, frm, par};
  wire [4:0] wclr   = {5{wr_en}} & arm & ~wr_data[7:3];

  wire rx_take = rx_done & ~rxf;

  wire set_txe = ~tx_enable | tx_load;
  wire set_rxf = rx_take & rx_stop_bit & ~rx_parity_bad;
  wire set_ovr = rx_done & rxf;
  wire set_frm = rx_take & ~rx_stop_bit;
  wire set_par = rx_take & rx_parity_bad;
  wire set_txd = ~tx_enable | (tx_last_bit & txe);
  wire [4:0] set5 = {set_txe, set_rxf, set_ovr, set_frm, set_par};

  wire clr_txe = txbuf_wr | wclr[4];
  wire clr_rxf = rxbuf_rd | wclr[3];

  assign rd_data = {txe, rxf, ovr, frm, par, txd, mpb_rx, mpb_tx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe    <= 1'b1;
      rxf    <= 1'b0;
      ovr    <= 1'b0;
      frm    <= 1'b0;
      par    <= 1'b0;
      txd    <= 1'b1;
      mpb_rx <= 1'b0;
      mpb_tx <= 1'b0;
      arm    <= '0;
    end else begin
      txe <= set_txe | (txe & ~clr_txe);
      rxf <= set_rxf | (rxf & ~clr_rxf);
      ovr <= set_ovr | (ovr & ~wclr[2]);
      frm <= set_frm | (frm & ~wclr[1]);
      par <= set_par | (par & ~wclr[0]);
      txd <= set_txd | (txd & ~clr_txe);
      if (rx_take) mpb_rx <= rx_mpb;
      if (wr_en)   mpb_tx <= wr_data[0];
      arm <= (wr_en ? 5'b0 : (rd_en ? flags5 : arm)) & ~set5;
    end
  end

  a_r1_reset_value: assert property (@(posedge clk) !rst_n |=> rd_data == 8'h84 || !rst_n);

  a_r3_txe_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txe) |-> $past(txbuf_wr || (wr_en && !wr_data[7])));

  a_r3_frm_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm) |-> $past(wr_en && !wr_data[4]));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rxf && !rx_stop_bit) |=> frm);

  a_r7_disable_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> txe && txd);

  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rxf) |=> ovr && rxf && $stable(mpb_rx));

  a_r9_ovr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_done && rxf));

  a_r11_mpb_tx: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mpb_tx == $past(wr_data[0]));

endmodule

// File: tb/sci_status_reg_test.sv
module sci_status_reg_test;
  logic clk = 0;
  logic rst_n = 0;
  logic rd_en = 0, wr_en = 0, txbuf_wr = 0, rxbuf_rd = 0, tx_enable = 1;
  logic tx_load = 0, tx_last_bit = 0, rx_done = 0, rx_stop_bit = 1, rx_parity_bad = 0, rx_mpb = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic mpb_tx;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  sci_status_reg uut (.*);

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic cyc; @(posedge clk); @(negedge clk); endtask

  task automatic do_read; rd_en = 1; cyc(); rd_en = 0; endtask
  task automatic do_write(input logic [7:0] d); wr_en = 1; wr_data = d; cyc(); wr_en = 0; endtask
  task automatic do_rx(input logic stp, input logic pb, input logic m);
    rx_done = 1; rx_stop_bit = stp; rx_parity_bad = pb; rx_mpb = m; cyc();
    rx_done = 0; rx_stop_bit = 1; rx_parity_bad = 0;
  endtask

  task automatic t_reset;
    check("R1 reset", 8'h84);
    do_write(8'h00);
    check("R3 write 0 without read", 8'h84);
  endtask

  task automatic t_tdre_clear;
    do_read();
    do_write(8'h7F);
    check("R3 R7 armed clear of bit7 also clears bit2", 8'h01);
    do_write(8'h00);
    check("R11 mpb_tx cleared", 8'h00);
  endtask

  task automatic t_tx_flow;
    tx_load = 1; cyc(); tx_load = 0;
    check("R6 load sets txe", 8'h80);
    tx_last_bit = 1; cyc(); tx_last_bit = 0;
    check("R7 last bit with txe", 8'h84);
    txbuf_wr = 1; cyc(); txbuf_wr = 0;
    check("R6 R7 buffer write clears", 8'h00);
    tx_last_bit = 1; cyc(); tx_last_bit = 0;
    check("R7 last bit without txe", 8'h00);
    tx_enable = 0; cyc(); tx_enable = 1;
    check("R6 R7 disable sets", 8'h84);
  endtask

  task automatic t_rx_flow;
    do_rx(1, 0, 1);
    check("R8 R11 good receive", 8'hC6);
    do_rx(1, 0, 0);
    check("R9 overrun", 8'hE6);
    rxbuf_rd = 1; cyc(); rxbuf_rd = 0;
    check("R8 buffer read clears", 8'hA6);
  endtask

  task automatic t_write_one;
    do_read();
    do_write(8'hFF);
    check("R3 write 1 no effect", 8'hA7);
    do_read();
    do_write(8'hDE);
    check("R3 clear overrun only", 8'h86);
  endtask

  task automatic t_errors;
    do_rx(0, 0, 0);
    check("R10 framing", 8'h94);
    do_rx(1, 1, 0);
    check("R10 parity", 8'h9C);
  endtask

  task automatic t_cancel;
    do_read();
    do_rx(0, 0, 0);
    do_write(8'h00);
    check("R4 set between read and write cancels arm", 8'h10);
  endtask

  task automatic t_same_cycle;
    do_read();
    wr_en = 1; wr_data = 8'h00; rx_done = 1; rx_stop_bit = 0; cyc();
    wr_en = 0; rx_done = 0; rx_stop_bit = 1;
    check("R5 set beats write clear", 8'h10);
    txbuf_wr = 1; tx_load = 1; cyc(); txbuf_wr = 0; tx_load = 0;
    check("R5 load beats buffer write", 8'h90);
  endtask

  task automatic t_disarm;
    do_read();
    do_write(8'hFF);
    do_write(8'h00);
    check("R4 write disarms", 8'h90);
    do_read();
    do_write(8'h00);
    check("R2 R3 armed clears", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tdre_clear();
    t_tx_flow();
    t_rx_flow();
    t_write_one();
    t_errors();
    t_cancel();
    t_same_cycle();
    t_disarm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule